// File: doc/BRIEF.md
# Chained-Descriptor DMA Sequencer

This block is the control half of a single-channel DMA engine. Software writes a list base address and issues a start command. The sequencer then reads an eight-word descriptor from memory through a simple read port, one word per request. It decodes the descriptor into transfer parameters and hands them to a separate data-moving engine with a one-cycle start pulse. It waits for that engine's done pulse, then follows the descriptor's next pointer to the following descriptor. This continues until a descriptor marked as the last one has been handled.

A two-bit channel status tells software what the channel is doing. A finished or timed-out result stays visible until a status read consumes it, after which the channel is idle again. Each transfer is watched by a programmable cycle limit. When the limit expires, the sequencer aborts the engine and stops walking the list. A reset command cancels the whole operation at any point. The next pointer is stored in one of two forms. A list held in system memory stores the byte address divided by 16, and the sequencer scales it back. A list held in local memory stores the byte address as it is.

Top module: `dma_desc_seq`

## Requirements
- R1: After rst_n is released, chan_stat is 0 (idle), and mem_rd_req, xfer_start and xfer_abort are low. The status encoding is 0 idle, 1 busy, 2 complete, 3 timeout.
- R2: A start command (cfg_wr with cfg_sel = 0) is taken only while chan_stat is 0, and chan_stat reads 1 from the following cycle on. In any other status the command has no effect.
- R3: Status values 2 and 3 are held until a cycle with stat_rd high, and chan_stat is 0 from the following cycle on. A stat_rd while chan_stat is 0 or 1 changes nothing.
- R4: A reset command (cfg_wr with cfg_sel = 1) makes chan_stat 0 in the next cycle and fetches nothing more. If a transfer is outstanding, xfer_abort is high in the cycle of the command.
- R5: A descriptor is read as eight words at byte addresses base+0, +4, … +28, in that order. Each read is a one-cycle mem_rd_req, and the next request comes only after mem_rd_valid has returned the previous word.
- R6: The bit layout of the descriptor words is fixed, and the decoded fields are presented on the xfer_* ports.
  - Word 0: [0] byte swap, [1] direction, [3:2] peripheral width.
  - Word 1: [15:0] length, [16] peripheral increment enable, [18:17] increment size.
  - Word 2: peripheral address.
  - Word 3: [2:0] access delay, [6:4] burst.
  - Word 4: [15:0] row count, [16] 2D enable.
  - Word 5: [15:0] line offset, [31:16] row length.
  - Word 6: memory address.
- R7: Word 7 holds the last-descriptor flag in bit 31 and the next pointer in bits [30:0]. The sequencer stops after the flagged descriptor and reports 2. Otherwise the next descriptor address is the pointer shifted left by 4 when list_sysmem was high at start, and the pointer unscaled when list_sysmem was low.
- R8: If list_sysmem and periph_local were both high at start, exactly one descriptor is processed, whatever its word 7 says.
- R9: A cfg write with cfg_sel = 3 sets the limit L from cfg_wdata[15:0]. If xfer_done has not arrived, xfer_abort pulses in the (L+1)th cycle after the xfer_start cycle. chan_stat then becomes 3 and no further descriptor is read.
- R10: A cfg write with cfg_sel = 2 sets the list base, and the first fetch of the next start uses it. xfer_start is a single-cycle pulse issued only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Command/register write strobe |
| cfg_sel | input | 2 | 0 start, 1 reset, 2 list base, 3 cycle limit |
| cfg_wdata | input | 32 | Write data |
| list_sysmem | input | 1 | List lives in system memory (sampled at start) |
| periph_local | input | 1 | Peripheral is local memory (sampled at start) |
| stat_rd | input | 1 | Status read strobe, consumes a final result |
| chan_stat | output | 2 | Channel status |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_abort | output | 1 | Transfer abort pulse |
| xfer_bswap | output | 1 | Byte swap |
| xfer_dir | output | 1 | Direction |
| xfer_pwidth | output | 2 | Peripheral width code |
| xfer_pincr_en | output | 1 | Peripheral address increment enable |
| xfer_pincr_sz | output | 2 | Peripheral increment size code |
| xfer_len | output | 16 | Transfer length |
| xfer_paddr | output | 32 | Peripheral address |
| xfer_acc_del | output | 3 | Access delay code |
| xfer_burst | output | 3 | Burst size |
| xfer_2d | output | 1 | 2D mode |
| xfer_rows | output | 16 | Row count |
| xfer_line_off | output | 16 | Line offset |
| xfer_row_len | output | 16 | Row length |
| xfer_maddr | output | 32 | Memory address |

## Verification
The assertions check the status rules on every cycle:
- a start from idle always gives busy;
- a final result holds until it is read and clears on the read;
- a reset command always lands in idle;
- requests and start pulses are single cycles;
- an abort always ends in the timeout status.

Only the bench scenarios can show the following:
- descriptor walking, over chains of one to four descriptors in both pointer forms;
- fetch addresses and field decoding;
- the single-descriptor restriction;
- the exact cycle of the timeout;
- the absence of fetches after a timeout or a reset.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_TMO  = 2'd3
    } chan_stat_e;

    typedef enum logic [2:0] {
        F_IDLE, F_REQ, F_WAIT, F_GO, F_XWAIT
    } seq_state_e;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_RESET = 2'd1;
    localparam logic [1:0] SEL_BASE  = 2'd2;
    localparam logic [1:0] SEL_LIMIT = 2'd3;

    typedef struct packed {
        logic        bswap;
        logic        dir;
        logic [1:0]  pwidth;
        logic        pincr_en;
        logic [1:0]  pincr_sz;
        logic [15:0] len;
        logic [31:0] paddr;
        logic [2:0]  acc_del;
        logic [2:0]  burst;
        logic        mode2d;
        logic [15:0] rows;
        logic [15:0] line_off;
        logic [15:0] row_len;
        logic [31:0] maddr;
    } xfer_par_t;
endpackage

// File: rtl/dds_decode.sv
module dds_decode
    import dds_pkg::*;
(
    input  desc_words_t words,
    output xfer_par_t   par
);
    always_comb begin
        par          = '0;
        par.bswap    = words[0][0];
        par.dir      = words[0][1];
        par.pwidth   = words[0][3:2];
        par.len      = words[1][15:0];
        par.pincr_en = words[1][16];
        par.pincr_sz = words[1][18:17];
        par.paddr    = words[2];
        par.acc_del  = words[3][2:0];
        par.burst    = words[3][6:4];
        par.rows     = words[4][15:0];
        par.mode2d   = words[4][16];
        par.line_off = words[5][15:0];
        par.row_len  = words[5][31:16];
        par.maddr    = words[6];
    end
endmodule

// File: rtl/dds_next_addr.sv
module dds_next_addr #(
    parameter int AW        = 32,
    parameter int SYS_SHIFT = 4
) (
    input  logic [31:0]   link_word,
    input  logic          in_sysmem,
    output logic          last,
    output logic [AW-1:0] next_addr
);
    localparam int PTR_W = 31;

    logic [PTR_W-1:0] ptr;
    logic [AW+SYS_SHIFT-1:0] wide;

    always_comb begin
        last = link_word[31];
        ptr  = link_word[PTR_W-1:0];
        wide = '0;
        if (in_sysmem) wide = (AW+SYS_SHIFT)'(ptr) << SYS_SHIFT;
        else           wide = (AW+SYS_SHIFT)'(ptr);
        next_addr = wide[AW-1:0];
    end
endmodule

// File: rtl/dds_xfer_timer.sv
module dds_xfer_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (run && cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dds_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TMO_W     = 16,
    parameter int SYS_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          list_sysmem,
    input  logic          periph_local,
    input  logic          stat_rd,
    output logic [1:0]    chan_stat,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [31:0]   mem_rd_data,
    output logic          xfer_start,
    input  logic          xfer_done,
    output logic          xfer_abort,
    output logic          xfer_bswap,
    output logic          xfer_dir,
    output logic [1:0]    xfer_pwidth,
    output logic          xfer_pincr_en,
    output logic [1:0]    xfer_pincr_sz,
    output logic [15:0]   xfer_len,
    output logic [31:0]   xfer_paddr,
    output logic [2:0]    xfer_acc_del,
    output logic [2:0]    xfer_burst,
    output logic          xfer_2d,
    output logic [15:0]   xfer_rows,
    output logic [15:0]   xfer_line_off,
    output logic [15:0]   xfer_row_len,
    output logic [31:0]   xfer_maddr
);
    localparam int BYTE_SH = $clog2(WORD_W / 8);

    typedef struct packed {
        seq_state_e    fsm;
        chan_stat_e    stat;
        logic [AW-1:0] base;
        logic [AW-1:0] ptr;
        logic [IDX_W-1:0] idx;
        logic [TMO_W-1:0] limit;
        logic          sys;
        logic          loc;
        desc_words_t   words;
    } seq_t;

    seq_t d, q;

    xfer_par_t     par;
    logic          last;
    logic [AW-1:0] next_addr;
    logic          expired;
    logic          cmd_start, cmd_reset, cmd_base, cmd_limit;

    dds_decode u_decode (.words(q.words), .par(par));

    dds_next_addr #(.AW(AW), .SYS_SHIFT(SYS_SHIFT)) u_next (
        .link_word (q.words[DESC_WORDS-1]),
        .in_sysmem (q.sys),
        .last      (last),
        .next_addr (next_addr)
    );

    dds_xfer_timer #(.CW(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (q.fsm == F_GO),
        .run     (q.fsm == F_XWAIT),
        .limit   (q.limit),
        .expired (expired)
    );

    assign cmd_start = cfg_wr && (cfg_sel == SEL_START);
    assign cmd_reset = cfg_wr && (cfg_sel == SEL_RESET);
    assign cmd_base  = cfg_wr && (cfg_sel == SEL_BASE);
    assign cmd_limit = cfg_wr && (cfg_sel == SEL_LIMIT);

    always_comb begin
        d = q;
        if (cmd_base)  d.base  = cfg_wdata[AW-1:0];
        if (cmd_limit) d.limit = cfg_wdata[TMO_W-1:0];
        case (q.fsm)
            F_IDLE: begin
                if (cmd_start && q.stat == ST_IDLE) begin
                    d.stat = ST_BUSY;
                    d.fsm  = F_REQ;
                    d.ptr  = q.base;
                    d.idx  = '0;
                    d.sys  = list_sysmem;
                    d.loc  = periph_local;
                end
            end
            F_REQ: d.fsm = F_WAIT;
            F_WAIT: begin
                if (mem_rd_valid) begin
                    d.words[q.idx] = mem_rd_data;
                    d.idx          = q.idx + 1'b1;
                    d.fsm          = (q.idx == IDX_W'(DESC_WORDS-1)) ? F_GO : F_REQ;
                end
            end
            F_GO: d.fsm = F_XWAIT;
            F_XWAIT: begin
                if (xfer_done) begin
                    if (last || (q.sys && q.loc)) begin
                        d.fsm  = F_IDLE;
                        d.stat = ST_DONE;
                    end else begin
                        d.fsm = F_REQ;
                        d.ptr = next_addr;
                        d.idx = '0;
                    end
                end else if (expired) begin
                    d.fsm  = F_IDLE;
                    d.stat = ST_TMO;
                end
            end
            default: d.fsm = F_IDLE;
        endcase
        if (stat_rd && q.stat[1]) d.stat = ST_IDLE;
        if (cmd_reset) begin
            d.fsm  = F_IDLE;
            d.stat = ST_IDLE;
            d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.fsm   <= F_IDLE;
            q.stat  <= ST_IDLE;
            q.limit <= '1;
        end else begin
            q <= d;
        end
    end

    assign chan_stat   = q.stat;
    assign mem_rd_req  = (q.fsm == F_REQ);
    assign mem_rd_addr = q.ptr + (AW'(q.idx) << BYTE_SH);
    assign xfer_start  = (q.fsm == F_GO);
    assign xfer_abort  = (q.fsm == F_XWAIT) && ((expired && !xfer_done) || cmd_reset);

    assign xfer_bswap    = par.bswap;
    assign xfer_dir      = par.dir;
    assign xfer_pwidth   = par.pwidth;
    assign xfer_pincr_en = par.pincr_en;
    assign xfer_pincr_sz = par.pincr_sz;
    assign xfer_len      = par.len;
    assign xfer_paddr    = par.paddr;
    assign xfer_acc_del  = par.acc_del;
    assign xfer_burst    = par.burst;
    assign xfer_2d       = par.mode2d;
    assign xfer_rows     = par.rows;
    assign xfer_line_off = par.line_off;
    assign xfer_row_len  = par.row_len;
    assign xfer_maddr    = par.maddr;
endmodule

// File: rtl/dds_checker.sv
module dds_checker
    import dds_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] cfg_sel,
    input logic       stat_rd,
    input logic [1:0] chan_stat,
    input logic       mem_rd_req,
    input logic       xfer_start,
    input logic       xfer_abort
);
    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_START && chan_stat == 2'd0) |=> chan_stat == 2'd1);

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_START && chan_stat[1] && !stat_rd) |=> $stable(chan_stat));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && chan_stat[1]) |=> chan_stat == 2'd0);

    assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_stat[1] && !stat_rd && !(cfg_wr && cfg_sel == SEL_RESET)) |=> $stable(chan_stat));

    assert_reset_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_RESET) |=> (chan_stat == 2'd0 && !mem_rd_req && !xfer_start));

    assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    assert_req_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> chan_stat == 2'd1);

    assert_abort_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_abort && !(cfg_wr && cfg_sel == SEL_RESET)) |=> chan_stat == 2'd3);

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (chan_stat == 2'd1) ##1 !xfer_start);
endmodule

bind dma_desc_seq dds_checker u_dds_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .stat_rd    (stat_rd),
    .chan_stat  (chan_stat),
    .mem_rd_req (mem_rd_req),
    .xfer_start (xfer_start),
    .xfer_abort (xfer_abort)
);

// File: tb/tb_dma_desc_seq.sv
module tb_dma_desc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        list_sysmem = 1'b0;
    logic        periph_local = 1'b0;
    logic        stat_rd = 1'b0;
    logic [1:0]  chan_stat;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        xfer_start;
    logic        xfer_done = 1'b0;
    logic        xfer_abort;
    logic        xfer_bswap, xfer_dir, xfer_pincr_en, xfer_2d;
    logic [1:0]  xfer_pwidth, xfer_pincr_sz;
    logic [15:0] xfer_len, xfer_rows, xfer_line_off, xfer_row_len;
    logic [31:0] xfer_paddr, xfer_maddr;
    logic [2:0]  xfer_acc_del, xfer_burst;

    always #2 clk = ~clk;

    dma_desc_seq dut (.*);

    int checks = 0;
    int fails  = 0;
    int mlat = 1, xlat = 1, tmo_lim = 0;
    bit hang = 1'b0;
    int rd_cnt = 0, xf_cnt = 0, abort_gap = 0;
    int seed = 0;
    logic [31:0] exp_desc [0:3];
    logic [31:0] mem [0:127];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: one word per request, after mlat cycles
    initial begin
        forever begin
            if (mem_rd_req === 1'b1) begin
                logic [31:0] a;
                a = mem_rd_addr;
                chk(a == exp_desc[(rd_cnt / 8) % 4] + 32'(4 * (rd_cnt % 8)), "R5 fetch address",
                    64'(a), 64'(exp_desc[(rd_cnt / 8) % 4] + 32'(4 * (rd_cnt % 8))));
                rd_cnt++;
                repeat (mlat) @(negedge clk);
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem[a[8:2]];
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // transfer engine model
    initial begin
        forever begin
            if (xfer_start === 1'b1) begin
                logic [6:0] b;
                b = exp_desc[xf_cnt % 4][8:2];
                chk({xfer_bswap, xfer_dir, xfer_pwidth, xfer_pincr_en, xfer_pincr_sz, xfer_len} ==
                    {mem[b][0], mem[b][1], mem[b][3:2], mem[b+1][16], mem[b+1][18:17], mem[b+1][15:0]},
                    "R6 words0-1", 64'({xfer_pincr_sz, xfer_len}), 64'({mem[b+1][18:17], mem[b+1][15:0]}));
                chk({xfer_acc_del, xfer_burst, xfer_2d, xfer_rows} ==
                    {mem[b+3][2:0], mem[b+3][6:4], mem[b+4][16], mem[b+4][15:0]},
                    "R6 words3-4", 64'({xfer_burst, xfer_rows}), 64'({mem[b+3][6:4], mem[b+4][15:0]}));
                chk({xfer_row_len, xfer_line_off} == mem[b+5], "R6 word5",
                    64'({xfer_row_len, xfer_line_off}), 64'(mem[b+5]));
                chk({xfer_paddr, xfer_maddr} == {mem[b+2], mem[b+6]}, "R6 words2-6",
                    {xfer_paddr, xfer_maddr}, {mem[b+2], mem[b+6]});
                xf_cnt++;
                if (hang) begin
                    abort_gap = 0;
                    while (xfer_abort !== 1'b1 && abort_gap < 200) begin
                        @(negedge clk);
                        abort_gap++;
                    end
                end else begin
                    repeat (xlat) @(negedge clk);
                    xfer_done = 1'b1;
                    @(negedge clk);
                    xfer_done = 1'b0;
                end
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [31:0] daddr(input int n, input int k);
        return 32'h10 + 32'(32'h40 * (n - 1 - k));
    endfunction

    task automatic build(input int n, input bit sys);
        seed++;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a, nx, pf;
            a = daddr(n, k);
            exp_desc[k] = a;
            for (int j = 0; j < 7; j++)
                mem[a[8:2] + 7'(j)] = (32'h9E3779B9 * 32'(k * 8 + j + 1)) ^ (32'h01234567 * 32'(seed));
            nx = daddr(n, k + 1);
            pf = sys ? (nx >> 4) : nx;
            mem[a[8:2] + 7'd7] = (k == n - 1) ? 32'h8000_0000 : {1'b0, pf[30:0]};
        end
    endtask

    task automatic launch(input int n, input bit sys, input bit loc);
        rd_cnt = 0; xf_cnt = 0;
        list_sysmem = sys; periph_local = loc;
        cfg(2'd2, daddr(n, 0));
        cfg(2'd0, 32'h0);
        chk(chan_stat == 2'd1, "R2 busy after start", 64'(chan_stat), 64'd1);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 4000 && chan_stat == 2'd1; i++) @(negedge clk);
    endtask

    task automatic run_chain(input int n, input bit sys, input bit loc, input int ml,
                             input int xl, input int expn, input bit poke);
        mlat = ml; xlat = xl; hang = 1'b0;
        build(n, sys);
        launch(n, sys, loc);
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg(2'd0, 32'h0);          // R2: start while busy is ignored
            read_stat();               // R3: read while busy has no effect
            chk(chan_stat == 2'd1, "R3 read during busy", 64'(chan_stat), 64'd1);
        end
        wait_end();
        chk(chan_stat == 2'd2, "R7 complete status", 64'(chan_stat), 64'd2);
        chk(xf_cnt == expn, loc && sys ? "R8 transfer count" : "R7 transfer count", 64'(xf_cnt), 64'(expn));
        chk(rd_cnt == 8 * expn, "R5 word reads", 64'(rd_cnt), 64'(8 * expn));
        if (poke) begin
            cfg(2'd0, 32'h0);          // R2: start while complete is ignored
            repeat (10) @(negedge clk);
            chk(chan_stat == 2'd2, "R2 start ignored when complete", 64'(chan_stat), 64'd2);
            chk(rd_cnt == 8 * expn, "R2 no fetch after ignored start", 64'(rd_cnt), 64'(8 * expn));
        end
        read_stat();
        chk(chan_stat == 2'd0, "R3 idle after read", 64'(chan_stat), 64'd0);
        @(negedge clk);
        chk(chan_stat == 2'd0, "R3 stays idle", 64'(chan_stat), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chan_stat == 2'd0, "R1 reset status", 64'(chan_stat), 64'd0);
        chk({mem_rd_req, xfer_start, xfer_abort} == 3'b000, "R1 reset outputs",
            64'({mem_rd_req, xfer_start, xfer_abort}), 64'd0);

        // sweep chain lengths and both pointer forms (R7, R10)
        for (int n = 1; n <= 4; n++)
            for (int s = 0; s < 2; s++)
                run_chain(n, s[0], 1'b0, 1 + n % 3, 1 + 2 * s, n, 1'b0);

        // R8: system-memory list with local peripheral -> single descriptor
        run_chain(3, 1'b1, 1'b1, 2, 2, 1, 1'b0);
        // local list with local peripheral walks the whole chain
        run_chain(3, 1'b0, 1'b1, 1, 1, 3, 1'b0);
        // R2/R3 ignore rules
        run_chain(2, 1'b0, 1'b0, 1, 6, 2, 1'b1);

        // R9: timeout
        tmo_lim = 6;
        cfg(2'd3, 32'(tmo_lim));
        mlat = 1; hang = 1'b1;
        build(2, 1'b0);
        launch(2, 1'b0, 1'b0);
        for (int i = 0; i < 100 && xf_cnt == 0; i++) @(negedge clk);
        repeat (tmo_lim - 1) @(negedge clk);
        chk(chan_stat == 2'd1, "R9 busy before limit", 64'(chan_stat), 64'd1);
        repeat (10) @(negedge clk);
        chk(abort_gap == tmo_lim + 1, "R9 abort cycle", 64'(abort_gap), 64'(tmo_lim + 1));
        chk(chan_stat == 2'd3, "R9 timeout status", 64'(chan_stat), 64'd3);
        repeat (20) @(negedge clk);
        chk(rd_cnt == 8, "R9 no fetch after timeout", 64'(rd_cnt), 64'd8);
        read_stat();
        chk(chan_stat == 2'd0, "R3 idle after timeout read", 64'(chan_stat), 64'd0);
        hang = 1'b0;
        cfg(2'd3, 32'd1000);

        // R4: reset command during an outstanding transfer
        mlat = 1; xlat = 30;
        build(3, 1'b0);
        launch(3, 1'b0, 1'b0);
        repeat (25) @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd1;
        #1;
        chk(xfer_abort == 1'b1, "R4 abort on reset command", 64'(xfer_abort), 64'd1);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(chan_stat == 2'd0, "R4 idle after reset command", 64'(chan_stat), 64'd0);
        repeat (40) @(negedge clk);
        chk(rd_cnt == 8 && xf_cnt == 1, "R4 nothing after reset command",
            64'({rd_cnt[15:0], xf_cnt[15:0]}), 64'({16'd8, 16'd1}));

        // R10: a fresh base after the reset command is honoured
        run_chain(1, 1'b1, 1'b0, 3, 2, 1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule